// File: doc/BRIEF.md
# Power-Good Delay Timer

This block turns the in-regulation status of a set of supply rails into three delayed power-good outputs. Each output channel owns a group of rails chosen by its own mask. When every rail in that group reports good at the same time, the channel starts counting millisecond ticks. It raises its power-good output once the selected delay has passed. If any rail in the group falls out of regulation, the channel drops its output straight away. The delay then starts again from zero the next time the whole group is good.

A single 8-bit delay register holds the delay codes for all three channels, and it can be written and read back. Channels 1 and 2 take a 3-bit code that selects one of eight non-linear delays. Channel 0 takes a 2-bit code with four choices. The rail status inputs are asynchronous, so each passes through a two-flop synchronizer. A free-running tick input, one pulse per millisecond, is the time base for every counter.

Top module: `pg_delay_timer`

## Requirements
- R1: After reset the delay register reads 8'h21: channel 1 code 1, channel 2 code 0, channel 0 code 1. Every power-good output is low.
- R2: A write to the delay register stores all 8 bits, and they read back unchanged on the next cycle.
- R3: Register bits [7:5] hold the channel 1 code, bits [4:2] hold the channel 2 code, and bits [1:0] hold the channel 0 code.
- R4: A 3-bit code of 0 to 7 selects a delay of 0, 5, 10, 15, 20, 50, 75 or 100 ticks, in that order.
- R5: The 2-bit code of channel 0, from 0 to 3, selects 0, 5, 10 or 15 ticks, in that order.
- R6: With a delay of 0, power-good rises at the clock edge after the synchronized group first shows as qualified. With a delay of N, it rises at the edge that samples the N-th tick counted after that point.
- R7: A group counts as qualified only while every rail in its mask is good. A partially good group never starts the delay.
- R8: When a rail in a qualified group goes bad, power-good falls on the same cycle that the synchronized status shows the loss. The count is cleared, and the next qualification restarts the delay from zero.
- R9: A channel whose mask is all zeros never asserts power-good.
- R10: A code written while a channel is counting leaves the current target unchanged. The new code applies from the channel's next qualification.
- R11: Each rail input passes through two flops. A change driven on a rail is first seen by the channels after the second rising clock edge.
- R12: Rails outside a channel's mask have no effect on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rail_ok | input | NUM_RAILS | Asynchronous in-regulation flags, one per rail |
| mask_ch0 | input | NUM_RAILS | Rail group for channel 0 |
| mask_ch1 | input | NUM_RAILS | Rail group for channel 1 |
| mask_ch2 | input | NUM_RAILS | Rail group for channel 2 |
| cfg_wr | input | 1 | Delay register write strobe |
| cfg_wdata | input | 8 | Delay register write data |
| cfg_rdata | output | 8 | Delay register contents |
| pg_out | output | 3 | Power-good per channel, bit i is channel i |

## Verification
Changing a code in the middle of a count is the hardest case to reach from the ports, because the new code lands on a channel that is already running. The stimulus qualifies channel 0 with a 15-tick code and issues two ticks. It then writes a 5-tick code and checks that the output stays low past tick 5 and rises exactly at tick 15. Next it drops and restores a rail. After that it checks that the 5-tick code now governs the delay. A loss of a rail in the middle of a count is driven the same way, to show that the restart begins from zero and does not resume the earlier count.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 7;
  localparam int NUM_CH = 3;

  function automatic logic [CNT_W-1:0] code_to_ms(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] ms;
    case (code)
      3'd0:    ms = 7'd0;
      3'd1:    ms = 7'd5;
      3'd2:    ms = 7'd10;
      3'd3:    ms = 7'd15;
      3'd4:    ms = 7'd20;
      3'd5:    ms = 7'd50;
      3'd6:    ms = 7'd75;
      default: ms = 7'd100;
    endcase
    return ms;
  endfunction
endpackage

// File: rtl/pgd_sync.sv
module pgd_sync #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic meta_q;
      logic stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= async_i[g];
          stab_q <= meta_q;
        end
      end
      assign sync_o[g] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/pgd_cfg_reg.sv
module pgd_cfg_reg #(
  parameter logic [7:0] RESET_VAL = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  logic [7:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (wr_i) val_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= RESET_VAL;
    else        val_q <= val_d;
  end

  assign rdata_o = val_q;

  // R2
  wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/pgd_channel.sv
module pgd_channel
  import pgd_pkg::*;
#(
  parameter int NUM_RAILS = 6,
  parameter int CW        = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [NUM_RAILS-1:0] rails_i,
  input  logic [NUM_RAILS-1:0] mask_i,
  input  logic [CW-1:0]        code_i,
  output logic                 pg_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             qual;
  logic [CNT_W-1:0] sel_ms;
  logic             active_q, active_d;
  logic             good_q, good_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic [CNT_W-1:0] cnt_inc;

  assign qual    = (|mask_i) && ((rails_i & mask_i) == mask_i);
  assign sel_ms  = code_to_ms(CODE_W'(code_i));
  assign cnt_inc = cnt_q + ONE;

  always_comb begin
    active_d = active_q;
    good_d   = good_q;
    cnt_d    = cnt_q;
    tgt_d    = tgt_q;
    if (!qual) begin
      active_d = 1'b0;
      good_d   = 1'b0;
      cnt_d    = '0;
    end else if (!active_q) begin
      active_d = 1'b1;
      cnt_d    = '0;
      tgt_d    = sel_ms;
      good_d   = (sel_ms == '0);
    end else if (!good_q && tick_i) begin
      cnt_d = cnt_inc;
      if (cnt_inc == tgt_q) good_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      good_q   <= 1'b0;
      cnt_q    <= '0;
      tgt_q    <= '0;
    end else begin
      active_q <= active_d;
      good_q   <= good_d;
      cnt_q    <= cnt_d;
      tgt_q    <= tgt_d;
    end
  end

  assign pg_o = good_q & qual;

  // R9
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> !pg_o);
  // R7
  rise_needs_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_q) |-> $past(qual));
  // R10
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && qual) |-> $stable(tgt_q));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q <= tgt_q));
endmodule

// File: rtl/pg_delay_timer.sv
module pg_delay_timer
  import pgd_pkg::*;
#(
  parameter int NUM_RAILS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ms_tick,
  input  logic [NUM_RAILS-1:0] rail_ok,
  input  logic [NUM_RAILS-1:0] mask_ch0,
  input  logic [NUM_RAILS-1:0] mask_ch1,
  input  logic [NUM_RAILS-1:0] mask_ch2,
  input  logic                 cfg_wr,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [NUM_CH-1:0]    pg_out
);
  logic [NUM_RAILS-1:0] rails_s;
  logic [7:0]           cfg;
  logic [NUM_RAILS-1:0] masks [NUM_CH];
  logic [CODE_W-1:0]    codes [NUM_CH];

  assign masks[0] = mask_ch0;
  assign masks[1] = mask_ch1;
  assign masks[2] = mask_ch2;
  // field positions decoded by the channels
  assign codes[0] = {1'b0, cfg[1:0]};
  assign codes[1] = cfg[7:5];
  assign codes[2] = cfg[4:2];

  pgd_sync #(.WIDTH(NUM_RAILS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rail_ok), .sync_o(rails_s)
  );

  pgd_cfg_reg #(.RESET_VAL(8'h21)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata), .rdata_o(cfg)
  );

  assign cfg_rdata = cfg;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int CW = (c == 0) ? 2 : 3;
      pgd_channel #(.NUM_RAILS(NUM_RAILS), .CW(CW)) u_ch (
        .clk(clk), .rst_n(rst_n), .tick_i(ms_tick), .rails_i(rails_s),
        .mask_i(masks[c]), .code_i(codes[c][CW-1:0]), .pg_o(pg_out[c])
      );
    end
  endgenerate
endmodule

// File: tb/pg_delay_timer_tb.sv
module pg_delay_timer_tb;
  localparam int NR = 6;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ms_tick = 1'b0;
  logic [NR-1:0] rail_ok = '0;
  logic [NR-1:0] mask_ch0 = 6'b000011;
  logic [NR-1:0] mask_ch1 = 6'b001100;
  logic [NR-1:0] mask_ch2 = 6'b110000;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic [2:0]    pg_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  pg_delay_timer #(.NUM_RAILS(NR)) u_dut (.*);

  always #2 clk = ~clk;

  function automatic int exp_ms(input int code);
    int t[8] = '{0, 5, 10, 15, 20, 50, 75, 100};
    return t[code];
  endfunction

  function automatic logic [NR-1:0] mask_of(input int ch);
    return (ch == 0) ? mask_ch0 : (ch == 1) ? mask_ch1 : mask_ch2;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; step(1); cfg_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) begin ms_tick = 1'b1; step(1); ms_tick = 1'b0; step(1); end
  endtask

  // qualify channel ch from all-low rails and check the delay
  task automatic run_delay(input string req, input int ch, input logic [7:0] cfgv, input int ms);
    rail_ok = '0; step(4); wr_cfg(cfgv);
    rail_ok = mask_of(ch);
    step(2); chk({req, " R11 sync"}, {7'd0, pg_out[ch]}, 8'd0);
    step(1);
    if (ms == 0) begin
      chk({req, " R6 zero"}, {7'd0, pg_out[ch]}, 8'd1);
    end else begin
      tick(ms - 1); chk({req, " R6 early"}, {7'd0, pg_out[ch]}, 8'd0);
      tick(1);      chk({req, " R6 expire"}, {7'd0, pg_out[ch]}, 8'd1);
    end
  endtask

  task automatic t_reset;
    chk("R1 reg", cfg_rdata, 8'h21);
    chk("R1 pg", {5'd0, pg_out}, 8'd0);
  endtask

  task automatic t_regrw;
    wr_cfg(8'hA6); chk("R2 a6", cfg_rdata, 8'hA6);
    wr_cfg(8'h5B); chk("R2 5b", cfg_rdata, 8'h5B);
  endtask

  task automatic t_tables;
    for (int k = 0; k < 8; k++)                 // R4 on channel 1, R3 bits 7:5
      run_delay("R4 R3 ch1", 1, {k[2:0], 5'b0}, exp_ms(k));
    run_delay("R3 ch2", 2, {3'd7, 3'd2, 2'd3}, 10);
    run_delay("R3 ch2b", 2, {3'd0, 3'd5, 2'd0}, 50);
    for (int k = 0; k < 4; k++)                 // R5 on channel 0, bits 1:0
      run_delay("R5 ch0", 0, {6'b111111, k[1:0]}, exp_ms(k));
  endtask

  task automatic t_partial;
    rail_ok = '0; step(4); wr_cfg(8'h01);
    rail_ok = 6'b000001; step(3); tick(20);
    chk("R7 partial", {7'd0, pg_out[0]}, 8'd0);
    rail_ok = 6'b000011; step(3); tick(5);
    chk("R7 full", {7'd0, pg_out[0]}, 8'd1);
    rail_ok = 6'b111111; step(3); rail_ok = 6'b010111; step(3);
    chk("R12 other rails", {7'd0, pg_out[0]}, 8'd1);
  endtask

  task automatic t_drop;
    run_delay("R8 setup", 1, 8'h60, 15);
    rail_ok = '0; step(1);
    chk("R11 drop latency", {7'd0, pg_out[1]}, 8'd1);
    step(1);
    chk("R8 drop", {7'd0, pg_out[1]}, 8'd0);
    rail_ok = mask_ch1; step(3); tick(10);
    rail_ok = 6'b000100; step(3);
    rail_ok = mask_ch1; step(3); tick(14);
    chk("R8 restart zero", {7'd0, pg_out[1]}, 8'd0);
    tick(1);
    chk("R8 restart expire", {7'd0, pg_out[1]}, 8'd1);
  endtask

  task automatic t_zero_mask;
    mask_ch2 = '0; rail_ok = '0; step(4); wr_cfg(8'h00);
    rail_ok = '1; step(6); tick(3);
    chk("R9 zero mask", {7'd0, pg_out[2]}, 8'd0);
    mask_ch2 = 6'b110000;
  endtask

  task automatic t_midchange;
    rail_ok = '0; step(4); wr_cfg(8'h03);
    rail_ok = mask_ch0; step(3); tick(2);
    wr_cfg(8'h01); tick(3);
    chk("R10 old target low", {7'd0, pg_out[0]}, 8'd0);
    tick(9);
    chk("R10 old target still low", {7'd0, pg_out[0]}, 8'd0);
    tick(1);
    chk("R10 old target expire", {7'd0, pg_out[0]}, 8'd1);
    rail_ok = '0; step(4); rail_ok = mask_ch0; step(3); tick(4);
    chk("R10 new early", {7'd0, pg_out[0]}, 8'd0);
    tick(1);
    chk("R10 new expire", {7'd0, pg_out[0]}, 8'd1);
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(2);
    t_reset();
    t_regrw();
    t_tables();
    t_partial();
    t_drop();
    t_zero_mask();
    t_midchange();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule